// File: doc/BRIEF.md
# Mobile tunnel traffic distributor

This block picks the back-end server for each decapsulated packet that leaves a mobile core tunnel probe. Upstream logic hands it one metadata word per packet: the operator group, the five-tuple, the gateway address, and flags for control traffic, keying mode and whether the packet carried a recognised tunnel. From these fields the block forms a 16-bit key hash. It reduces the hash modulo the length of that group's server list and reads the chosen entry. The entry gives an output port number and a replacement destination MAC address. Both leave the block through a valid/ready handshake.

There are three ways to form the key. In flow mode all five tuple fields are hashed, and the hash is the same in either direction. In subscriber mode only the terminal IP address is hashed, so uplink and downlink packets of one user reach the same server. The direction comes from a flag bit in the source MAC. Control packets are always keyed by the gateway address.

Each group has its own list of up to eight entries, which software writes in advance. Software writes go to a staging copy. That copy is moved into the live table only while no packet is waiting in the hash stage. A packet therefore sees one consistent table from the moment it is accepted until its result is produced.

Top module: `tunnel_dist`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With in_ctrl=0 and in_mode=0, the hash is SIP[31:16]^SIP[15:0]^DIP[31:16]^DIP[15:0]^SPORT^DPORT^{8'h00,PROTO}. The selected slot is hash modulo the group's list length.
- R3: In flow mode, a packet with source and destination addresses and ports swapped selects the same port as the original.
- R4: With in_ctrl=0 and in_mode=1, bit 0 of in_src_mac marks uplink. On uplink the hash is SIP[31:16]^SIP[15:0], otherwise it is DIP[31:16]^DIP[15:0].
- R5: With in_ctrl=1, the hash is GW[31:16]^GW[15:0], whatever in_mode is.
- R6: out_port and out_dmac equal the port and MAC stored in the selected slot of the packet's group.
- R7: Each group has its own table, so the same key in different groups can select different ports.
- R8: A packet with in_tunnel_ok=0 is accepted but produces no output.
- R9: A list-length write with a value of 0 or above 8 is ignored, and the length stays as it was. After reset every length is 1.
- R10: Table writes made in the same cycle as a packet's acceptance, or while it waits in the hash stage, do not affect that packet. They apply to packets accepted once the hash stage has drained.
- R11: While out_valid=1 and out_ready=0, out_valid, out_port and out_dmac hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len_sel | input | 1 | 1: write list length, 0: write table slot |
| cfg_grp | input | 2 | Group being configured |
| cfg_idx | input | 3 | Slot being configured |
| cfg_port | input | 5 | Port number for the slot |
| cfg_mac | input | 48 | Destination MAC for the slot |
| cfg_len | input | 4 | New list length (1..8) |
| in_valid | input | 1 | Metadata valid |
| in_ready | output | 1 | Metadata accepted this cycle |
| in_grp | input | 2 | Operator group |
| in_mode | input | 1 | 0 flow key, 1 subscriber key |
| in_ctrl | input | 1 | Control packet, keyed by gateway |
| in_tunnel_ok | input | 1 | Packet came from a recognised tunnel |
| in_src_mac | input | 48 | Source MAC; bit 0 is the uplink flag |
| in_src_ip | input | 32 | Inner source IP |
| in_dst_ip | input | 32 | Inner destination IP |
| in_src_port | input | 16 | Inner source L4 port |
| in_dst_port | input | 16 | Inner destination L4 port |
| in_proto | input | 8 | Inner IP protocol |
| in_gw_ip | input | 32 | Gateway address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_port | output | 5 | Chosen output port |
| out_dmac | output | 48 | Replacement destination MAC |

## Verification
The assertions assume the downstream side follows the handshake. They also assume software never writes a length outside 1..8 with the intent of it taking effect. The block rejects such values, so the live length seen by the hash stage always lies in 1..8, and the slot index is always below it. The bench keeps its table writes and packet sends in separate negedge-driven tasks. It stalls the output only on purpose, to hold a packet in the hash stage while the table is rewritten. Every other packet goes through a drained pipeline with out_ready held high.

// File: rtl/tdist_pkg.sv
package tdist_pkg;
  localparam int HASH_W = 16;

  function automatic logic [HASH_W-1:0] fold32(input logic [31:0] v);
    return v[31:16] ^ v[15:0];
  endfunction

  // symmetric: xor of both ends is order independent
  function automatic logic [HASH_W-1:0] flow_hash(
    input logic [31:0] sip, input logic [31:0] dip,
    input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] proto);
    return fold32(sip ^ dip) ^ (sp ^ dp) ^ {8'h00, proto};
  endfunction

  function automatic logic [HASH_W-1:0] pick_hash(
    input logic ctrl, input logic mode, input logic uplink,
    input logic [31:0] sip, input logic [31:0] dip,
    input logic [15:0] sp, input logic [15:0] dp,
    input logic [7:0] proto, input logic [31:0] gw);
    if (ctrl) return fold32(gw);
    if (mode) return fold32(uplink ? sip : dip);
    return flow_hash(sip, dip, sp, dp, proto);
  endfunction
endpackage

// File: rtl/tdist_key_hash.sv
module tdist_key_hash
  import tdist_pkg::*;
(
  input  logic              ctrl,
  input  logic              mode,
  input  logic              uplink,
  input  logic [31:0]       sip,
  input  logic [31:0]       dip,
  input  logic [15:0]       sp,
  input  logic [15:0]       dp,
  input  logic [7:0]        proto,
  input  logic [31:0]       gw,
  output logic [HASH_W-1:0] hash
);
  always_comb hash = pick_hash(ctrl, mode, uplink, sip, dip, sp, dp, proto, gw);
endmodule

// File: rtl/tdist_slot_sel.sv
module tdist_slot_sel #(
  parameter int HW = 16,
  parameter int IW = 3,
  parameter int LW = IW + 1
) (
  input  logic [HW-1:0] hash,
  input  logic [LW-1:0] len,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] reduce(input logic [HW-1:0] h, input logic [LW-1:0] l);
    logic [HW-1:0] r;
    r = h % HW'(l);
    return r[IW-1:0];
  endfunction

  always_comb idx = reduce(hash, len);
endmodule

// File: rtl/tdist_port_table.sv
module tdist_port_table #(
  parameter int NGRP  = 4,
  parameter int NSLOT = 8,
  parameter int PORTW = 5,
  parameter int MACW  = 48,
  localparam int GW   = $clog2(NGRP),
  localparam int IW   = $clog2(NSLOT),
  localparam int LW   = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_len_sel,
  input  logic [GW-1:0]    cfg_grp,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [PORTW-1:0] cfg_port,
  input  logic [MACW-1:0]  cfg_mac,
  input  logic [LW-1:0]    cfg_len,
  input  logic             commit,
  input  logic [GW-1:0]    rd_grp,
  input  logic [IW-1:0]    rd_idx,
  output logic [LW-1:0]    rd_len,
  output logic [PORTW-1:0] rd_port,
  output logic [MACW-1:0]  rd_mac
);
  logic [LW-1:0]    stg_len  [NGRP];
  logic [LW-1:0]    live_len [NGRP];
  logic [PORTW-1:0] stg_port [NGRP][NSLOT];
  logic [PORTW-1:0] live_port[NGRP][NSLOT];
  logic [MACW-1:0]  stg_mac  [NGRP][NSLOT];
  logic [MACW-1:0]  live_mac [NGRP][NSLOT];

  logic len_ok;
  assign len_ok = (cfg_len != '0) && (cfg_len <= LW'(NSLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        stg_len[g]  <= LW'(1);
        live_len[g] <= LW'(1);
        for (int s = 0; s < NSLOT; s++) begin
          stg_port[g][s]  <= '0;
          live_port[g][s] <= '0;
          stg_mac[g][s]   <= '0;
          live_mac[g][s]  <= '0;
        end
      end
    end else begin
      if (cfg_we && cfg_len_sel && len_ok) stg_len[cfg_grp] <= cfg_len;
      if (cfg_we && !cfg_len_sel) begin
        stg_port[cfg_grp][cfg_idx] <= cfg_port;
        stg_mac[cfg_grp][cfg_idx]  <= cfg_mac;
      end
      if (commit) begin
        live_len  <= stg_len;
        live_port <= stg_port;
        live_mac  <= stg_mac;
      end
    end
  end

  assign rd_len  = live_len[rd_grp];
  assign rd_port = live_port[rd_grp][rd_idx];
  assign rd_mac  = live_mac[rd_grp][rd_idx];
endmodule

// File: rtl/tunnel_dist.sv
module tunnel_dist
  import tdist_pkg::*;
#(
  parameter int NGRP    = 4,
  parameter int NSLOT   = 8,
  parameter int PORTW   = 5,
  parameter int MACW    = 48,
  parameter int DIR_BIT = 0,
  localparam int GW     = $clog2(NGRP),
  localparam int IW     = $clog2(NSLOT),
  localparam int LW     = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_len_sel,
  input  logic [GW-1:0]    cfg_grp,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [PORTW-1:0] cfg_port,
  input  logic [MACW-1:0]  cfg_mac,
  input  logic [LW-1:0]    cfg_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [GW-1:0]    in_grp,
  input  logic             in_mode,
  input  logic             in_ctrl,
  input  logic             in_tunnel_ok,
  input  logic [MACW-1:0]  in_src_mac,
  input  logic [31:0]      in_src_ip,
  input  logic [31:0]      in_dst_ip,
  input  logic [15:0]      in_src_port,
  input  logic [15:0]      in_dst_port,
  input  logic [7:0]       in_proto,
  input  logic [31:0]      in_gw_ip,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PORTW-1:0] out_port,
  output logic [MACW-1:0]  out_dmac
);
  // hash stage
  logic              a_vld;
  logic [GW-1:0]     a_grp;
  logic [HASH_W-1:0] a_hash;
  logic [LW-1:0]     a_len;
  logic [IW-1:0]     a_idx;
  // output stage
  logic              b_vld;
  logic [PORTW-1:0]  b_port;
  logic [MACW-1:0]   b_mac;
  // named events
  logic              b_take, a_adv, accept, tbl_commit;
  logic [HASH_W-1:0] new_hash;
  logic [PORTW-1:0]  rd_port;
  logic [MACW-1:0]   rd_mac;

  assign b_take     = !b_vld || out_ready;
  assign a_adv      = a_vld && b_take;
  assign in_ready   = !a_vld || b_take;
  assign accept     = in_valid && in_ready && in_tunnel_ok;
  assign tbl_commit = !a_vld;

  tdist_key_hash u_hash (
    .ctrl(in_ctrl), .mode(in_mode), .uplink(in_src_mac[DIR_BIT]),
    .sip(in_src_ip), .dip(in_dst_ip), .sp(in_src_port), .dp(in_dst_port),
    .proto(in_proto), .gw(in_gw_ip), .hash(new_hash)
  );

  tdist_slot_sel #(.HW(HASH_W), .IW(IW), .LW(LW)) u_sel (
    .hash(a_hash), .len(a_len), .idx(a_idx)
  );

  tdist_port_table #(.NGRP(NGRP), .NSLOT(NSLOT), .PORTW(PORTW), .MACW(MACW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_len_sel(cfg_len_sel), .cfg_grp(cfg_grp),
    .cfg_idx(cfg_idx), .cfg_port(cfg_port), .cfg_mac(cfg_mac), .cfg_len(cfg_len),
    .commit(tbl_commit), .rd_grp(a_grp), .rd_idx(a_idx),
    .rd_len(a_len), .rd_port(rd_port), .rd_mac(rd_mac)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_grp  <= '0;
      a_hash <= '0;
    end else if (accept) begin
      a_vld  <= 1'b1;
      a_grp  <= in_grp;
      a_hash <= new_hash;
    end else if (a_adv) begin
      a_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld  <= 1'b0;
      b_port <= '0;
      b_mac  <= '0;
    end else if (b_take) begin
      b_vld <= a_vld;
      if (a_vld) begin
        b_port <= rd_port;
        b_mac  <= rd_mac;
      end
    end
  end

  assign out_valid = b_vld;
  assign out_port  = b_port;
  assign out_dmac  = b_mac;
endmodule

// File: rtl/tdist_chk.sv
module tdist_chk #(
  parameter int NSLOT = 8,
  parameter int PORTW = 5,
  parameter int MACW  = 48,
  parameter int IW    = 3,
  parameter int LW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PORTW-1:0] out_port,
  input logic [MACW-1:0]  out_dmac,
  input logic             a_vld,
  input logic [IW-1:0]    a_idx,
  input logic [LW-1:0]    a_len,
  input logic             tbl_commit
);
  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_dmac));

  p_table_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> !tbl_commit);

  p_slot_in_list_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> ({1'b0, a_idx} < a_len));

  p_len_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> (a_len != '0) && (a_len <= LW'(NSLOT)));
endmodule

bind tunnel_dist tdist_chk #(.NSLOT(NSLOT), .PORTW(PORTW), .MACW(MACW), .IW(IW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_port(out_port), .out_dmac(out_dmac), .a_vld(a_vld), .a_idx(a_idx),
  .a_len(a_len), .tbl_commit(tbl_commit)
);

// File: tb/test_tunnel_dist.sv
module test_tunnel_dist;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_len_sel = 0;
  logic [1:0] cfg_grp = 0;
  logic [2:0] cfg_idx = 0;
  logic [4:0] cfg_port = 0;
  logic [47:0] cfg_mac = 0;
  logic [3:0] cfg_len = 0;
  logic in_valid = 0, in_mode = 0, in_ctrl = 0, in_tunnel_ok = 0;
  logic in_ready;
  logic [1:0] in_grp = 0;
  logic [47:0] in_src_mac = 0;
  logic [31:0] in_src_ip = 0, in_dst_ip = 0, in_gw_ip = 0;
  logic [15:0] in_src_port = 0, in_dst_port = 0;
  logic [7:0] in_proto = 0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [4:0] out_port;
  logic [47:0] out_dmac;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tunnel_dist i_tunnel_dist (.*);

  // grp[141:140] mode[139] ctrl[138] dir[137] ok[136] sip dip sp dp proto gw
  localparam int NV = 8;
  localparam logic [141:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,1'b0,1'b1,32'hC0A80001,32'h0A000005,16'h1234,16'h0050,8'h06,32'h0},
    {2'd1,1'b0,1'b0,1'b0,1'b1,32'hC0A80001,32'h0A000005,16'h1234,16'h0050,8'h06,32'h0},
    {2'd2,1'b1,1'b0,1'b1,1'b1,32'h0A0A0A01,32'h08080808,16'h9000,16'h01BB,8'h06,32'h0},
    {2'd2,1'b1,1'b0,1'b0,1'b1,32'h08080808,32'h0A0A0A01,16'h01BB,16'h9000,8'h06,32'h0},
    {2'd3,1'b1,1'b1,1'b0,1'b1,32'h11111111,32'h22222222,16'h0001,16'h0002,8'h11,32'hAC100001},
    {2'd3,1'b0,1'b0,1'b0,1'b1,32'hDEADBEEF,32'h01020304,16'hF00D,16'h0035,8'h11,32'h0},
    {2'd1,1'b0,1'b0,1'b1,1'b1,32'h64400007,32'hC6336401,16'hABCD,16'h1F90,8'h06,32'h0},
    {2'd0,1'b0,1'b1,1'b0,1'b1,32'h0A000001,32'h0A000002,16'h0007,16'h0008,8'h06,32'hAC10FE09}
  };

  logic [4:0]  m_port [4][8];
  logic [47:0] m_mac  [4][8];
  int          m_len  [4];

  function automatic logic [15:0] ref_hash(input logic [141:0] v);
    logic [31:0] sip, dip, gw, k;
    sip = v[135:104]; dip = v[103:72]; gw = v[31:0];
    if (v[138]) k = gw;
    else if (v[139]) k = v[137] ? sip : dip;
    else return sip[15:0] ^ dip[31:16] ^ sip[31:16] ^ dip[15:0]
              ^ v[55:40] ^ v[71:56] ^ {8'h00, v[39:32]};
    return k[15:0] ^ k[31:16];
  endfunction

  function automatic int ref_slot(input logic [141:0] v);
    return int'(ref_hash(v)) % m_len[v[141:140]];
  endfunction

  function automatic logic [141:0] swap_ends(input logic [141:0] v);
    logic [141:0] r;
    r = v;
    r[135:104] = v[103:72]; r[103:72] = v[135:104];
    r[71:56] = v[55:40];    r[55:40] = v[71:56];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_slot(input int g, input int s, input logic [4:0] p, input logic [47:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_len_sel = 0; cfg_grp = 2'(g); cfg_idx = 3'(s); cfg_port = p; cfg_mac = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_len(input int g, input int l);
    @(negedge clk);
    cfg_we = 1; cfg_len_sel = 1; cfg_grp = 2'(g); cfg_len = 4'(l);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [141:0] v);
    @(negedge clk);
    in_valid = 1; in_grp = v[141:140]; in_mode = v[139]; in_ctrl = v[138];
    in_src_mac = {47'h010203040500 >> 1, v[137]};
    in_tunnel_ok = v[136];
    in_src_ip = v[135:104]; in_dst_ip = v[103:72];
    in_src_port = v[71:56]; in_dst_port = v[55:40]; in_proto = v[39:32]; in_gw_ip = v[31:0];
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic recv(output logic [4:0] p, output logic [47:0] m, output bit got);
    got = 0; p = 0; m = 0;
    for (int i = 0; i < 12; i++) begin
      if (out_valid) begin
        got = 1; p = out_port; m = out_dmac; break;
      end
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [141:0] v, input string tag);
    logic [4:0] p; logic [47:0] m; bit got; int s;
    s = ref_slot(v);
    send(v);
    recv(p, m, got);
    check({tag, " got"}, 64'(got), 64'd1);
    check({tag, " port"}, 64'(p), 64'(m_port[v[141:140]][s]));
    check("R6 dmac", 64'(m), 64'(m_mac[v[141:140]][s]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] p1, p2, pa, pb; logic [47:0] mm; bit got;
    logic [4:0] exp1, exp2;
    for (int g = 0; g < 4; g++) begin
      m_len[g] = 1;
      for (int s = 0; s < 8; s++) begin m_port[g][s] = 0; m_mac[g][s] = 0; end
    end
    repeat (3) @(negedge clk);
    check("R1 out_valid", 64'(out_valid), 0);
    check("R1 in_ready", 64'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after release", 64'(out_valid), 0);

    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 8; s++) begin
        m_port[g][s] = 5'(g * 8 + s);
        m_mac[g][s]  = 48'h0A0000000000 | 48'(g << 8) | 48'(s);
        wr_slot(g, s, m_port[g][s], m_mac[g][s]);
      end
      m_len[g] = (g == 3) ? 8 : g + 3;
      wr_len(g, m_len[g]);
    end
    repeat (2) @(negedge clk);

    // table walk: R2 flow, R4 subscriber, R5 control, R6 slot contents
    for (int i = 0; i < NV; i++)
      run_vec(VEC[i], VEC[i][138] ? "R5" : (VEC[i][139] ? "R4" : "R2"));

    // R4: uplink and downlink of one user land together
    check("R4 same user both ways", 64'(ref_slot(VEC[2])), 64'(ref_slot(VEC[3])));

    // R3: swapped flow
    send(VEC[6]); recv(pa, mm, got);
    send(swap_ends(VEC[6])); recv(pb, mm, got);
    check("R3 swapped flow", 64'(pb), 64'(pa));

    // R7: same key, groups 0 and 1 differ
    send(VEC[0]); recv(pa, mm, got);
    send(VEC[1]); recv(pb, mm, got);
    check("R7 groups differ", 64'(pa != pb), 64'd1);

    // R8: non-tunnel packet dropped
    begin
      logic [141:0] v; int seen;
      v = VEC[5]; v[136] = 1'b0; seen = 0;
      send(v);
      for (int i = 0; i < 6; i++) begin
        if (out_valid) seen++;
        @(negedge clk);
      end
      check("R8 dropped", 64'(seen), 0);
    end

    // R9: illegal lengths ignored
    wr_len(0, 0);
    wr_len(0, 9);
    repeat (2) @(negedge clk);
    run_vec(VEC[7], "R9");

    // R10/R11: rewrite group 1 while a packet waits in the hash stage
    exp1 = m_port[1][ref_slot(VEC[1])];
    exp2 = m_port[1][ref_slot(VEC[6])];
    @(negedge clk); out_ready = 0;
    send(VEC[1]);
    send(VEC[6]);
    for (int s = 0; s < 8; s++) begin
      m_port[1][s] = 5'(31 - s);
      m_mac[1][s]  = 48'h0B0000000000 | 48'(s);
      wr_slot(1, s, m_port[1][s], m_mac[1][s]);
    end
    m_len[1] = 2;
    wr_len(1, 2);
    check("R11 held while stalled", 64'(out_valid), 1);
    check("R11 port held", 64'(out_port), 64'(exp1));
    recv(p1, mm, got);
    recv(p2, mm, got);
    check("R10 first stalled packet old table", 64'(p1), 64'(exp1));
    check("R10 waiting packet old table", 64'(p2), 64'(exp2));
    repeat (2) @(negedge clk);
    run_vec(VEC[6], "R10 new table");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule